// File: doc/BRIEF.md
# Frame-synchronous window register controller

This block keeps the per-window layout settings of a multi-window display pipeline in two copies. Software writes go to a visible bank, and software reads come back from it. The display pipeline reads a second, active bank. Frame-synchronous fields move from the visible bank to the active bank only on the vsync pulse, which is the same instant the pipeline restarts its fetch. Software can therefore rewrite a window while a frame is being scanned out without tearing it.

Each window has a protect bit in one shared control word. While a window's protect bit is set, that window's active copy is frozen. Software can then rewrite the buffer start, buffer end, line geometry, position and window enable as one set. The intended order is:

1. Set protect.
2. Write the buffer and position registers.
3. Set the window enable and the channel enable.
4. Clear protect.

The whole set is then applied at the next vsync. The same control word also carries an immediate DMA channel enable for each window. A global video control word has an immediate enable bit and a frame-synchronous enable bit.

Each window is tracked by a three-state machine:

| State | Meaning |
|---|---|
| `W_SYNCED` | The active copy matches the visible copy. |
| `W_PENDING` | Written values are waiting for the next vsync. |
| `W_LOCKED` | The window is protected. |

Its transitions:

| From | To | Condition |
|---|---|---|
| `W_SYNCED` | `W_PENDING` | Write without vsync |
| `W_PENDING` | `W_SYNCED` | vsync while unprotected (the copy is made) |
| any state | `W_LOCKED` | Protect set |
| `W_LOCKED` | `W_SYNCED` | Protect clear and vsync (the copy is made) |
| `W_LOCKED` | `W_PENDING` | Protect clear without vsync |

Top module: `shd_win_ctrl`

## Requirements

- R1: After reset both banks, all protect bits, all channel enables and both video enable bits are zero. `bus_rdata` is zero and every active output is zero.

- R2: The register address is `{window[2:0], reg[2:0]}`.
  - Window register codes: reg 0 buffer start, reg 1 buffer end, reg 2 geometry/pitch, reg 3 position, reg 4 window enable (bit 0).
  - Window index 7 is global: reg 0 video control, reg 1 protect/channel word.
  - A write with `bus_valid=1`, `bus_write=1` lands in the visible bank at that clock edge.
  - A read with `bus_valid=1`, `bus_write=0` presents the visible (not active) value on `bus_rdata` after that edge.

- R3: The active outputs of a window change only at a clock edge at which `vsync` is high.

- R4: For an unprotected window, a vsync copies all of the window's visible fields to its active copy, including the window enable.

- R5: While protect bit `w` is set, vsync leaves window `w`'s active copy unchanged. Other, unprotected windows are still updated.

- R6: Once protect is cleared, the next vsync transfers the values written while the window was protected.

- R7: If a write to an unprotected window and a vsync occur in the same cycle, the active copy takes the newly written value.

- R8: Writing the geometry register with visible width in [11:0], frame-buffer width in [23:12] and bytes-per-pixel minus one in [25:24] stores a pitch word:
  - page width = visible width × bytes per pixel, in [15:0];
  - line-skip offset = (frame-buffer width − visible width) × bytes per pixel, in [31:16].

  Reading the register returns that pitch word.

- R9: In the protect/channel word, bits [4:0] are the per-window protect bits and bits [9:5] are the per-window channel enables. `dma_chan_en` follows a write to the word immediately, that is, after the write edge.

- R10: In the video control word, bit 0 drives `video_on` immediately. Bit 1 reaches `video_on_frame` only at a vsync.

- R11: The following addresses are unmapped:
  - window indices 5 and 6;
  - window registers 5 to 7;
  - global registers 2 to 7.

  Writes to an unmapped address change no register, and reads from one return zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register address {window, reg} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| vsync | input | 1 | Frame boundary pulse, one cycle |
| pipe_win | input | 3 | Window whose active copy is presented |
| act_start | output | 32 | Active buffer start of `pipe_win` |
| act_end | output | 32 | Active buffer end of `pipe_win` |
| act_pitch | output | 32 | Active pitch word of `pipe_win` |
| act_pos | output | 32 | Active position of `pipe_win` |
| act_win_en | output | 1 | Active window enable of `pipe_win` |
| video_on | output | 1 | Immediate video enable |
| video_on_frame | output | 1 | Frame-synchronous video enable |
| dma_chan_en | output | 5 | Per-window DMA channel enable |

## Verification

The bench targets four corner cases:

- **Protect window.** A start address is written, protect is raised, and a vsync arrives. A design that ignores protect would leak the half-written value to the pipeline. A second window written in the same frame must still update, which catches a protect bit that freezes every window.
- **Release.** After protect is cleared, the very next vsync must apply the held value. A design that drops the pending state would stay stale.
- **Write in the vsync cycle.** A write coinciding with vsync must reach the active copy. A design that copies the old visible register would lose it for a whole frame.
- **Pitch arithmetic and address decode.** The pitch word is checked for a wide frame buffer and for a zero offset. The unmapped addresses are checked for aliasing onto real windows.

// File: rtl/shd_pkg.sv
package shd_pkg;

    localparam int CFG_W = 32;
    localparam int GEO_W = 12;
    localparam int HALF_W = CFG_W / 2;

    typedef struct packed {
        logic [CFG_W-1:0] start;
        logic [CFG_W-1:0] stop;
        logic [CFG_W-1:0] pitch;
        logic [CFG_W-1:0] pos;
        logic             en;
    } win_cfg_t;

    typedef enum logic [1:0] {
        W_SYNCED  = 2'd0,
        W_PENDING = 2'd1,
        W_LOCKED  = 2'd2
    } wstate_e;

    localparam logic [2:0] RG_START = 3'd0;
    localparam logic [2:0] RG_END   = 3'd1;
    localparam logic [2:0] RG_GEOM  = 3'd2;
    localparam logic [2:0] RG_POS   = 3'd3;
    localparam logic [2:0] RG_CTRL  = 3'd4;

    localparam logic [2:0] GL_IDX   = 3'd7;
    localparam logic [2:0] GL_VIDEO = 3'd0;
    localparam logic [2:0] GL_SHADOW = 3'd1;

    function automatic logic [CFG_W-1:0] geom_to_pitch(input logic [CFG_W-1:0] g);
        logic [GEO_W-1:0]  vis;
        logic [GEO_W-1:0]  fbw;
        logic [2:0]        bytes;
        logic [HALF_W-1:0] page;
        logic [HALF_W-1:0] skip;
        vis   = g[GEO_W-1:0];
        fbw   = g[2*GEO_W-1:GEO_W];
        bytes = {1'b0, g[2*GEO_W+1:2*GEO_W]} + 3'd1;
        page  = HALF_W'(vis * bytes);
        skip  = HALF_W'((fbw - vis) * bytes);
        return {skip, page};
    endfunction

endpackage

// File: rtl/shd_win_fsm.sv
module shd_win_fsm
    import shd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic vsync,
    input  logic prot,
    output logic load
);

    wstate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_SYNCED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_SYNCED: begin
                if (prot)                state_d = W_LOCKED;
                else if (wr_hit && !vsync) state_d = W_PENDING;
            end
            W_PENDING: begin
                if (prot)       state_d = W_LOCKED;
                else if (vsync) state_d = W_SYNCED;
            end
            W_LOCKED: begin
                if (!prot) state_d = vsync ? W_SYNCED : W_PENDING;
            end
            default: state_d = W_SYNCED;
        endcase
    end

    always_comb begin
        load = 1'b0;
        unique case (state_q)
            W_SYNCED:  load = vsync && !prot && wr_hit;
            W_PENDING: load = vsync && !prot;
            W_LOCKED:  load = vsync && !prot;
            default:   load = 1'b0;
        endcase
    end

    // R5: a protected window is always in the locked state one cycle later
    p_locked_follows_protect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot |=> (state_q == W_LOCKED));

    // R6: a window that is unprotected and sees vsync never stays pending
    p_release_applies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot && vsync) |=> (state_q != W_PENDING));

endmodule

// File: rtl/shd_win_bank.sv
module shd_win_bank
    import shd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             load,
    output win_cfg_t         vis_q,
    output win_cfg_t         shd_q
);

    win_cfg_t vis_d;

    always_comb begin
        vis_d = vis_q;
        if (wr_en) begin
            unique case (wr_sel)
                RG_START: vis_d.start = wr_data;
                RG_END:   vis_d.stop  = wr_data;
                RG_GEOM:  vis_d.pitch = geom_to_pitch(wr_data);
                RG_POS:   vis_d.pos   = wr_data;
                RG_CTRL:  vis_d.en    = wr_data[0];
                default:  vis_d = vis_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= '0;
            shd_q <= '0;
        end else begin
            vis_q <= vis_d;
            if (load) shd_q <= vis_d;
        end
    end

endmodule

// File: rtl/shd_win_ctrl.sv
module shd_win_ctrl
    import shd_pkg::*;
#(
    parameter int NWIN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [5:0]       bus_addr,
    input  logic [CFG_W-1:0] bus_wdata,
    output logic [CFG_W-1:0] bus_rdata,
    input  logic             vsync,
    input  logic [2:0]       pipe_win,
    output logic [CFG_W-1:0] act_start,
    output logic [CFG_W-1:0] act_end,
    output logic [CFG_W-1:0] act_pitch,
    output logic [CFG_W-1:0] act_pos,
    output logic             act_win_en,
    output logic             video_on,
    output logic             video_on_frame,
    output logic [NWIN-1:0]  dma_chan_en
);

    localparam int CTL_W = 2 * NWIN;

    logic [2:0] a_win, a_reg;
    logic       wr_any, rd_any, glob_sel, win_reg_ok;
    logic [NWIN-1:0] win_wr, load, prot;
    logic [CTL_W-1:0] shctl_q;
    logic [1:0] vid_q;
    logic       vid_frame_q;
    win_cfg_t   vis [NWIN];
    win_cfg_t   shd [NWIN];

    assign a_win      = bus_addr[5:3];
    assign a_reg      = bus_addr[2:0];
    assign wr_any     = bus_valid && bus_write;
    assign rd_any     = bus_valid && !bus_write;
    assign glob_sel   = (a_win == GL_IDX);
    assign win_reg_ok = (a_reg <= RG_CTRL);
    assign prot        = shctl_q[NWIN-1:0];
    assign dma_chan_en = shctl_q[CTL_W-1:NWIN];
    assign video_on       = vid_q[0];
    assign video_on_frame = vid_frame_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign win_wr[w] = wr_any && (a_win == 3'(w)) && win_reg_ok;

        shd_win_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (win_wr[w]),
            .vsync  (vsync),
            .prot   (prot[w]),
            .load   (load[w])
        );

        shd_win_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (win_wr[w]),
            .wr_sel  (a_reg),
            .wr_data (bus_wdata),
            .load    (load[w]),
            .vis_q   (vis[w]),
            .shd_q   (shd[w])
        );

        p_protect_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            prot[w] |=> $stable(shd[w]));

        p_only_at_vsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !vsync |=> $stable(shd[w]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shctl_q     <= '0;
            vid_q       <= '0;
            vid_frame_q <= 1'b0;
        end else begin
            if (wr_any && glob_sel && a_reg == GL_SHADOW) shctl_q <= bus_wdata[CTL_W-1:0];
            if (wr_any && glob_sel && a_reg == GL_VIDEO)  vid_q   <= bus_wdata[1:0];
            if (vsync) begin
                vid_frame_q <= (wr_any && glob_sel && a_reg == GL_VIDEO) ? bus_wdata[1] : vid_q[1];
            end
        end
    end

    logic [CFG_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (glob_sel) begin
            if (a_reg == GL_VIDEO)       rd_val = CFG_W'(vid_q);
            else if (a_reg == GL_SHADOW) rd_val = CFG_W'(shctl_q);
        end else if (a_win < 3'(NWIN)) begin
            for (int w = 0; w < NWIN; w++) begin
                if (a_win == 3'(w)) begin
                    unique case (a_reg)
                        RG_START: rd_val = vis[w].start;
                        RG_END:   rd_val = vis[w].stop;
                        RG_GEOM:  rd_val = vis[w].pitch;
                        RG_POS:   rd_val = vis[w].pos;
                        RG_CTRL:  rd_val = CFG_W'(vis[w].en);
                        default:  rd_val = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_any) bus_rdata <= rd_val;
    end

    always_comb begin
        act_start  = '0;
        act_end    = '0;
        act_pitch  = '0;
        act_pos    = '0;
        act_win_en = 1'b0;
        for (int w = 0; w < NWIN; w++) begin
            if (pipe_win == 3'(w)) begin
                act_start  = shd[w].start;
                act_end    = shd[w].stop;
                act_pitch  = shd[w].pitch;
                act_pos    = shd[w].pos;
                act_win_en = shd[w].en;
            end
        end
    end

    p_chan_en_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && glob_sel && a_reg == GL_SHADOW) |=> (dma_chan_en == $past(bus_wdata[CTL_W-1:NWIN])));

    p_frame_video_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(video_on_frame));

    p_unmapped_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !glob_sel && (a_win >= 3'(NWIN))) |=> (bus_rdata == '0));

endmodule

// File: tb/shd_win_ctrl_test.sv
module shd_win_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, vsync = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  pipe_win = '0;
    logic [31:0] bus_rdata, act_start, act_end, act_pitch, act_pos;
    logic        act_win_en, video_on, video_on_frame;
    logic [4:0]  dma_chan_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shd_win_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vsync(vsync), .pipe_win(pipe_win), .act_start(act_start), .act_end(act_end),
        .act_pitch(act_pitch), .act_pos(act_pos), .act_win_en(act_win_en),
        .video_on(video_on), .video_on_frame(video_on_frame), .dma_chan_en(dma_chan_en)
    );

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_VS = 3'd2, OP_AS = 3'd3, OP_AP = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{OP_WR, 6'd0,  32'h0000_1000, 32'h0},           // R2 window 0 start
        '{OP_RD, 6'd0,  32'h0,         32'h0000_1000},   // R2 visible readback
        '{OP_AS, 6'd0,  32'h0,         32'h0},           // R3 not yet active
        '{OP_VS, 6'd0,  32'h0,         32'h0},
        '{OP_AS, 6'd0,  32'h0,         32'h0000_1000},   // R4 applied at vsync
        '{OP_WR, 6'd10, 32'h030A_0064, 32'h0},           // R8 vis 100 fb 160 4 bytes
        '{OP_RD, 6'd10, 32'h0,         32'h00F0_0190},   // R8 pitch word
        '{OP_VS, 6'd0,  32'h0,         32'h0},
        '{OP_AP, 6'd1,  32'h0,         32'h00F0_0190},   // R4 pitch active
        '{OP_WR, 6'd2,  32'h0114_0140, 32'h0},           // R8 vis 320 fb 320 2 bytes
        '{OP_VS, 6'd0,  32'h0,         32'h0},
        '{OP_AP, 6'd0,  32'h0,         32'h0000_0280},   // R8 zero offset
        '{OP_WR, 6'd57, 32'h0000_0002, 32'h0},           // R5 protect window 1
        '{OP_WR, 6'd8,  32'h0000_2000, 32'h0},           // R5 write while protected
        '{OP_WR, 6'd0,  32'h0000_3000, 32'h0},           // R5 window 0 unprotected
        '{OP_VS, 6'd0,  32'h0,         32'h0},
        '{OP_AS, 6'd1,  32'h0,         32'h0},           // R5 window 1 held
        '{OP_AS, 6'd0,  32'h0,         32'h0000_3000},   // R5 window 0 still updated
        '{OP_RD, 6'd8,  32'h0,         32'h0000_2000},   // R2 visible, not active
        '{OP_WR, 6'd57, 32'h0000_0000, 32'h0},           // R6 release
        '{OP_AS, 6'd1,  32'h0,         32'h0},           // R6 nothing before vsync
        '{OP_VS, 6'd0,  32'h0,         32'h0},
        '{OP_AS, 6'd1,  32'h0,         32'h0000_2000},   // R6 applied on next vsync
        '{OP_RD, 6'd57, 32'h0,         32'h0}            // R9 word readback
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_vs();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        pipe_win = 3'd0; #1;
        check("R1 act_start", act_start, 32'h0);
        check("R1 act_win_en", {31'h0, act_win_en}, 32'h0);
        check("R1 dma_chan_en", {27'h0, dma_chan_en}, 32'h0);
        check("R1 video", {30'h0, video_on, video_on_frame}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_WR: do_wr(VECS[i].addr, VECS[i].data);
                OP_RD: begin
                    do_rd(VECS[i].addr, rv);
                    check("R2/R8/R9 readback", rv, VECS[i].exp);
                end
                OP_VS: do_vs();
                OP_AS: begin
                    @(negedge clk); pipe_win = VECS[i].addr[2:0]; #1;
                    check("R3-R6 act_start", act_start, VECS[i].exp);
                end
                default: begin
                    @(negedge clk); pipe_win = VECS[i].addr[2:0]; #1;
                    check("R4/R8 act_pitch", act_pitch, VECS[i].exp);
                end
            endcase
        end

        // R7 write and vsync in the same cycle
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'd0; bus_wdata = 32'h0000_5555; vsync = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; vsync = 1'b0;
        pipe_win = 3'd0; #1;
        check("R7 same-cycle write", act_start, 32'h0000_5555);

        // R4 window enable, end and position travel at vsync
        do_wr(6'd4, 32'h1);
        do_wr(6'd3, 32'h0010_0020);
        do_wr(6'd1, 32'h0000_9000);
        #1 check("R3 enable not yet", {31'h0, act_win_en}, 32'h0);
        do_vs(); #1;
        check("R4 window enable", {31'h0, act_win_en}, 32'h1);
        check("R4 position", act_pos, 32'h0010_0020);
        check("R4 buffer end", act_end, 32'h0000_9000);

        // R9 channel enables immediate
        do_wr(6'd57, 32'h0000_03E0); #1;
        check("R9 dma_chan_en", {27'h0, dma_chan_en}, 32'h1F);
        do_rd(6'd57, rv);
        check("R9 readback", rv, 32'h0000_03E0);

        // R10 video control
        do_wr(6'd56, 32'h3); #1;
        check("R10 immediate bit", {31'h0, video_on}, 32'h1);
        check("R10 frame bit waits", {31'h0, video_on_frame}, 32'h0);
        do_vs(); #1;
        check("R10 frame bit at vsync", {31'h0, video_on_frame}, 32'h1);

        // R11 unmapped addresses
        do_wr(6'd40, 32'hDEAD_BEEF);
        do_wr(6'd7,  32'hDEAD_BEEF);
        do_wr(6'd58, 32'hDEAD_BEEF);
        do_rd(6'd40, rv); check("R11 window 5 reads zero", rv, 32'h0);
        do_rd(6'd7,  rv); check("R11 reg 7 reads zero", rv, 32'h0);
        do_rd(6'd58, rv); check("R11 global reg 2 reads zero", rv, 32'h0);
        do_rd(6'd0,  rv); check("R11 no alias to window 0", rv, 32'h0000_5555);
        do_vs(); pipe_win = 3'd0; #1;
        check("R11 active window 0 untouched", act_start, 32'h0000_5555);
        #1 check("R11 channel word untouched", {27'h0, dma_chan_en}, 32'h1F);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule